// File: doc/BRIEF.md
# Framed Serial Transmitter with Line-Driver Direction Control

This block turns one parallel character into an asynchronous serial frame on a single transmit line. The frame shape is chosen at run time for each character: the number of data bits (five to nine), the parity mode (none, even or odd) and the number of stop bits (one or two). The bit period comes from an internal divider whose ratio is fixed by two parameters, the clock frequency and the bit rate. A character is offered on a valid/ready handshake and latched into a single holding register together with the frame settings in force at that moment.

For half-duplex links the block drives an enable for an external line driver. The enable goes active one whole bit period before the start bit and stays active until one whole bit period after the last stop bit. Its active level is selected by an input. A flow-control input from the far end can hold off new frames. It is synchronized first and only consulted between frames, so a frame that has begun always runs to its end. When the driver is released and the line is idle again, a one-cycle completion pulse is raised and the handshake becomes ready again.

Top module: `serial_tx_linectl`

## Requirements
- R1: While reset is held and in the first cycle after it, `txd` is 1 and `tx_done` is 0, and `line_drv_en` is at the inverse of `cfg_de_pol`. Between frames `txd` stays 1.
- R2: Every frame element lasts exactly DIV = CLK_HZ/BAUD clock cycles. After a character is accepted the elements are sent in this order: one lead-in period with `txd` high, one start period with `txd` low, the data bits, the optional parity bit, the stop bits, and one trailing period with `txd` high.
- R3: `cfg_len` gives the data length in bits. Codes 5 to 9 are used as given, codes below 5 are treated as 5, and codes above 9 are treated as 9. Bit 0 of `in_data` is sent first, and bits above the length are not sent.
- R4: `cfg_parity` 1 selects even parity and 2 selects odd parity. Codes 0 and 3 send no parity bit. With even parity the parity bit makes the number of ones among the data and parity bits even; with odd parity it makes that number odd. The parity bit follows the last data bit.
- R5: When the data length is 9, no parity bit is sent whatever `cfg_parity` holds.
- R6: `cfg_two_stop` = 0 sends one high stop period and 1 sends two.
- R7: `cts` passes through a two-stage synchronizer that resets to 1. While the synchronized value is 1, `in_ready` is 0 and no frame starts. A change of `cts` during a frame does not alter that frame.
- R8: During a frame (lead-in to trailing period inclusive) `line_drv_en` equals `cfg_de_pol` as sampled at acceptance. Outside a frame it equals the inverse of the current `cfg_de_pol`.
- R9: `tx_done` is high for exactly one cycle: the first cycle after the trailing period. In that same cycle `line_drv_en` returns to its inactive level.
- R10: A character is accepted on a clock edge where `in_valid` and `in_ready` are both 1. From that edge until `tx_done` is raised, `in_ready` is 0. Changes to `in_data`, `cfg_len`, `cfg_parity`, `cfg_two_stop` and `cfg_de_pol` during that time do not affect the frame in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_len | input | 4 | Data length code, clamped to 5..9 |
| cfg_parity | input | 2 | 0 none, 1 even, 2 odd, 3 none |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_de_pol | input | 1 | Active level of the driver enable |
| cts | input | 1 | Far-end flow control; 1 holds off new frames |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Character can be accepted |
| in_data | input | 9 | Character, bit 0 sent first |
| txd | output | 1 | Serial line, idles high |
| line_drv_en | output | 1 | Half-duplex line-driver enable |
| tx_done | output | 1 | One-cycle pulse when a frame ends |

## Verification
The assertions assume that every input is settled well before each rising clock edge. The only exception is `cts`, which may change at any time because it is sampled through the synchronizer. They also assume that reset is held for at least two cycles, so that the synchronizer and the divider start from known values. The bench meets these assumptions by changing all inputs on the falling edge and by holding reset for four cycles. It changes `cts` while the block is idle, while a character is waiting, and in the middle of a frame. It also deliberately changes the data and frame settings while a frame is in flight.

// File: rtl/stx_pkg.sv
package stx_pkg;

  localparam int MIN_BITS = 5;
  localparam int MAX_BITS = 9;
  localparam int LEN_W    = 4;
  localparam int IDX_W    = $clog2(MAX_BITS + 1);

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD,
    PH_START,
    PH_DATA,
    PH_PAR,
    PH_STOP,
    PH_TRAIL
  } phase_t;

  typedef enum logic [1:0] {
    PAR_NONE  = 2'd0,
    PAR_EVEN  = 2'd1,
    PAR_ODD   = 2'd2,
    PAR_NONE2 = 2'd3
  } par_mode_t;

  function automatic logic [IDX_W-1:0] clamp_len(input logic [LEN_W-1:0] code);
    if (code < LEN_W'(MIN_BITS))      return IDX_W'(MIN_BITS);
    else if (code > LEN_W'(MAX_BITS)) return IDX_W'(MAX_BITS);
    else                              return IDX_W'(code);
  endfunction

endpackage

// File: rtl/stx_sync.sv
module stx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] ff;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) ff <= RST_VAL;
        else     ff <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) ff <= {STAGES{RST_VAL}};
        else     ff <= {ff[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = ff[STAGES-1];

endmodule

// File: rtl/stx_baud_gen.sv
module stx_baud_gen #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);

  localparam int            CW   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart)   cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);

  // R2: the period counter never leaves its range
  a_r2_count_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

  // R2: after a restart a full period elapses before the next tick
  a_r2_restart_full: assert property (@(posedge clk) disable iff (rst)
    (restart && DIV > 1) |=> !tick);

endmodule

// File: rtl/stx_framer.sv
module stx_framer
  import stx_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                cts_hold,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic [1:0]          cfg_parity,
  input  logic                cfg_two_stop,
  input  logic                cfg_de_pol,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [MAX_BITS-1:0] in_data,
  output logic                restart,
  output logic                txd,
  output logic                line_drv_en,
  output logic                tx_done
);

  phase_t              st;
  logic [MAX_BITS-1:0] sh;
  logic [IDX_W-1:0]    len_l;
  logic [IDX_W-1:0]    idx;
  logic                par_on_l;
  logic                par_bit_l;
  logic                two_l;
  logic                second;
  logic                pol_l;
  logic                de_act;

  logic [IDX_W-1:0]    len_eff;
  logic [MAX_BITS-1:0] masked;
  logic                par_on;
  logic                par_val;
  logic                accept;

  always_comb begin
    len_eff = clamp_len(cfg_len);
    for (int i = 0; i < MAX_BITS; i++)
      masked[i] = in_data[i] & (IDX_W'(i) < len_eff);
    par_on  = ((cfg_parity == PAR_EVEN) || (cfg_parity == PAR_ODD)) &&
              (len_eff != IDX_W'(MAX_BITS));
    par_val = (^masked) ^ (cfg_parity == PAR_ODD);
  end

  assign in_ready    = (st == PH_IDLE) && !cts_hold;
  assign accept      = in_valid && in_ready;
  assign restart     = accept;
  assign line_drv_en = de_act ? pol_l : ~pol_l;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= PH_IDLE;
      sh        <= '0;
      len_l     <= IDX_W'(MIN_BITS);
      idx       <= '0;
      par_on_l  <= 1'b0;
      par_bit_l <= 1'b0;
      two_l     <= 1'b0;
      second    <= 1'b0;
      pol_l     <= cfg_de_pol;
      de_act    <= 1'b0;
      txd       <= 1'b1;
      tx_done   <= 1'b0;
    end else begin
      tx_done <= 1'b0;
      if (st == PH_IDLE) pol_l <= cfg_de_pol;
      unique case (st)
        PH_IDLE: begin
          if (accept) begin
            sh        <= in_data;
            len_l     <= len_eff;
            par_on_l  <= par_on;
            par_bit_l <= par_val;
            two_l     <= cfg_two_stop;
            de_act    <= 1'b1;
            st        <= PH_LEAD;
          end
        end
        PH_LEAD: if (tick) begin
          txd <= 1'b0;
          st  <= PH_START;
        end
        PH_START: if (tick) begin
          txd <= sh[0];
          sh  <= sh >> 1;
          idx <= IDX_W'(1);
          st  <= PH_DATA;
        end
        PH_DATA: if (tick) begin
          if (idx == len_l) begin
            second <= 1'b0;
            if (par_on_l) begin
              txd <= par_bit_l;
              st  <= PH_PAR;
            end else begin
              txd <= 1'b1;
              st  <= PH_STOP;
            end
          end else begin
            txd <= sh[0];
            sh  <= sh >> 1;
            idx <= idx + 1'b1;
          end
        end
        PH_PAR: if (tick) begin
          txd <= 1'b1;
          st  <= PH_STOP;
        end
        PH_STOP: if (tick) begin
          if (two_l && !second) second <= 1'b1;
          else                  st     <= PH_TRAIL;
        end
        PH_TRAIL: if (tick) begin
          de_act  <= 1'b0;
          tx_done <= 1'b1;
          st      <= PH_IDLE;
        end
        default: st <= PH_IDLE;
      endcase
    end
  end

  // R2: the line only moves on a bit boundary
  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(txd));

  // R1: an idle line is high
  a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
    (st == PH_IDLE) |-> txd);

  // R7: a held-off block stays idle
  a_r7_cts_blocks: assert property (@(posedge clk) disable iff (rst)
    (st == PH_IDLE && cts_hold) |=> (st == PH_IDLE));

  // R8: the driver is already on when the start bit begins
  a_r8_de_at_start: assert property (@(posedge clk) disable iff (rst)
    $fell(txd) |-> (line_drv_en == pol_l));

  // R9: completion is a single-cycle pulse with the driver released
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    tx_done |=> !tx_done);
  a_r9_done_released: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> (line_drv_en != pol_l) && txd);

  // R10: acceptance drops ready on the next cycle
  a_r10_ready_drop: assert property (@(posedge clk) disable iff (rst)
    accept |=> !in_ready);

endmodule

// File: rtl/serial_tx_linectl.sv
module serial_tx_linectl
  import stx_pkg::*;
#(
  parameter int CLK_HZ     = 250_000_000,
  parameter int BAUD       = 25_000_000,
  parameter int CTS_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic [1:0]          cfg_parity,
  input  logic                cfg_two_stop,
  input  logic                cfg_de_pol,
  input  logic                cts,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [MAX_BITS-1:0] in_data,
  output logic                txd,
  output logic                line_drv_en,
  output logic                tx_done
);

  localparam int DIV = (CLK_HZ / BAUD < 1) ? 1 : CLK_HZ / BAUD;

  logic cts_hold;
  logic bit_tick;
  logic restart;

  stx_sync #(.STAGES(CTS_STAGES), .RST_VAL(1'b1)) u_cts_sync (
    .clk (clk),
    .rst (rst),
    .d   (cts),
    .q   (cts_hold)
  );

  stx_baud_gen #(.DIV(DIV)) u_baud (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .tick    (bit_tick)
  );

  stx_framer u_framer (
    .clk          (clk),
    .rst          (rst),
    .tick         (bit_tick),
    .cts_hold     (cts_hold),
    .cfg_len      (cfg_len),
    .cfg_parity   (cfg_parity),
    .cfg_two_stop (cfg_two_stop),
    .cfg_de_pol   (cfg_de_pol),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_data      (in_data),
    .restart      (restart),
    .txd          (txd),
    .line_drv_en  (line_drv_en),
    .tx_done      (tx_done)
  );

endmodule

// File: tb/serial_tx_linectl_test.sv
`timescale 1ns/1ps
module serial_tx_linectl_test;

  localparam int CLK_HZ = 250_000_000;
  localparam int BAUD   = 31_250_000;
  localparam int DIV    = CLK_HZ / BAUD;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] cfg_len = 4'd8;
  logic [1:0] cfg_parity = 2'd0;
  logic       cfg_two_stop = 1'b0;
  logic       cfg_de_pol = 1'b1;
  logic       cts = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [8:0] in_data = '0;
  logic       txd, line_drv_en, tx_done;

  always #2 clk = ~clk;

  serial_tx_linectl #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) uut (
    .clk(clk), .rst(rst), .cfg_len(cfg_len), .cfg_parity(cfg_parity),
    .cfg_two_stop(cfg_two_stop), .cfg_de_pol(cfg_de_pol), .cts(cts),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .txd(txd), .line_drv_en(line_drv_en), .tx_done(tx_done)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    finished = 0;

  // reference model
  bit m_busy = 0, m_done = 0, m_c1 = 1, m_c2 = 1, m_pol = 1;
  int m_cnt = 0;
  bit m_q[$];

  function automatic bit m_ready();
    return !m_busy && !m_c2;
  endfunction

  task automatic build_frame(input logic [8:0] d, input logic [3:0] lc,
                             input logic [1:0] pm, input logic two);
    int  n;
    int  ones;
    bit  pon;
    n = (lc < 5) ? 5 : ((lc > 9) ? 9 : int'(lc));
    pon = (pm == 2'd1 || pm == 2'd2) && (n != 9);
    m_q.delete();
    m_q.push_back(1'b1);
    m_q.push_back(1'b0);
    ones = 0;
    for (int i = 0; i < n; i++) begin
      m_q.push_back(d[i]);
      if (d[i]) ones++;
    end
    if (pon) m_q.push_back((pm == 2'd1) ? bit'(ones % 2) : bit'((ones + 1) % 2));
    m_q.push_back(1'b1);
    if (two) m_q.push_back(1'b1);
    m_q.push_back(1'b1);
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_c1 = 1; m_c2 = 1; m_cnt = 0;
      m_pol = cfg_de_pol;
      m_q.delete();
    end else begin
      bit acc;
      acc = in_valid && m_ready();
      m_done = 0;
      if (!m_busy) m_pol = cfg_de_pol;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == DIV) begin
          m_cnt = 0;
          void'(m_q.pop_front());
          if (m_q.size() == 0) begin
            m_busy = 0;
            m_done = 1;
          end
        end
      end else if (acc) begin
        build_frame(in_data, cfg_len, cfg_parity, cfg_two_stop);
        m_busy = 1;
        m_cnt = 0;
      end
      m_c2 = m_c1;
      m_c1 = cts;
    end
  end

  task automatic chk(input logic act, input logic exp, input string nm);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %b expected %b at %0t", cur_req, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(txd, m_busy ? m_q[0] : 1'b1, "txd");
      chk(line_drv_en, m_busy ? m_pol : ~m_pol, "line_drv_en");
      chk(tx_done, m_done, "tx_done");
      chk(in_ready, m_ready(), "in_ready");
    end
  end

  task automatic send(input logic [8:0] d, input logic [3:0] lc,
                      input logic [1:0] pm, input logic two);
    in_data = d; cfg_len = lc; cfg_parity = pm; cfg_two_stop = two;
    in_valid = 1'b1;
    do @(negedge clk); while (!m_busy);
    in_valid = 1'b0;
    // R10: disturb everything the frame latched
    in_data = ~d; cfg_len = 4'd5; cfg_parity = ~pm; cfg_two_stop = ~two;
    while (m_busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    cur_req = "R1";
    chk(txd, 1'b1, "txd after reset");
    chk(tx_done, 1'b0, "tx_done after reset");
    chk(line_drv_en, 1'b0, "line_drv_en after reset");
    repeat (5) @(negedge clk);

    cur_req = "R2";  send(9'h0A5, 4'd8, 2'd0, 1'b0);
    cur_req = "R3";  send(9'h013, 4'd5, 2'd0, 1'b0);
    send(9'h1FF, 4'd3, 2'd0, 1'b0);
    send(9'h155, 4'd12, 2'd0, 1'b0);
    cur_req = "R4";  send(9'h05B, 4'd7, 2'd1, 1'b0);
    send(9'h05B, 4'd7, 2'd2, 1'b0);
    send(9'h03C, 4'd6, 2'd3, 1'b0);
    send(9'h000, 4'd8, 2'd2, 1'b0);
    cur_req = "R5";  send(9'h1A5, 4'd9, 2'd1, 1'b0);
    send(9'h0F0, 4'd9, 2'd2, 1'b1);
    cur_req = "R6";  send(9'h081, 4'd8, 2'd2, 1'b1);
    send(9'h00E, 4'd6, 2'd0, 1'b1);
    cur_req = "R8";
    cfg_de_pol = 1'b0;
    repeat (3) @(negedge clk);
    send(9'h0C3, 4'd8, 2'd1, 1'b0);
    cfg_de_pol = 1'b1;
    repeat (3) @(negedge clk);
    cur_req = "R7";
    cts = 1'b1;
    repeat (3) @(negedge clk);
    fork
      send(9'h066, 4'd8, 2'd0, 1'b0);
      begin repeat (30) @(negedge clk); cts = 1'b0; end
    join
    fork
      send(9'h199, 4'd9, 2'd0, 1'b1);
      begin repeat (25) @(negedge clk); cts = 1'b1; end
    join
    repeat (10) @(negedge clk);
    cts = 1'b0;
    repeat (4) @(negedge clk);
    cur_req = "R9";  send(9'h07E, 4'd7, 2'd1, 1'b1);
    cur_req = "R10"; send(9'h0AA, 4'd8, 2'd2, 1'b0);
    send(9'h155, 4'd9, 2'd0, 1'b0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL %s watchdog: got running expected finished", cur_req);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule